// File: doc/BRIEF.md
# Qualified Programmable Event Counter

This block is one programmable performance counter for a processor core. Every cycle it is handed a bank of per-cycle occurrence counts, organised as groups of sub-events, together with the privilege level the core is running at. A control register picks one group by its event code. A unit mask then picks which of that group's sub-events are added together. The resulting per-cycle total passes through a threshold comparison that can be inverted, an optional rising-edge detector and a privilege filter. What is left is added to a 40-bit counter.

Software reaches the control register, the counter and a sticky overflow status bit through a small register port. Writes take effect at the clock edge and reads are combinational. When the counter carries out of its top bit, the status bit is set. While interrupts are enabled in the control register, the status bit drives the interrupt output. Two small state machines carry the sequential behaviour. The edge tracker moves between `EDG_LOW` and `EDG_HIGH`: it goes from low to high when the qualified condition is true, from high to low when it is false, and from either state to low when the control register is written. The overflow tracker moves between `OVF_IDLE` and `OVF_PEND`: it goes from idle to pending on a carry out, and from pending back to idle when software clears the status bit in a cycle with no new carry.

Top module: `qual_event_counter`

## Requirements
- R1: Register map. Address 0 is control, address 1 is the 40-bit counter and address 2 is status, with the sticky overflow flag in bit 0. Control fields: event code [7:0], unit mask [15:8], user-level enable 16, kernel-level enable 17, edge mode 18, interrupt enable 19, invert 20, global enable 21, threshold [31:24].
- R2: Group g (0..3) answers to event code 0x20+g, and any other code selects nothing. The per-cycle total is the sum of the sub-event counts whose unit-mask bit is set. A unit mask of zero selects sub-event 0 alone.
- R3: With threshold zero and edge mode off, the counter adds the full per-cycle total.
- R4: With a nonzero threshold, the counter adds one in each cycle whose total is greater than or equal to the threshold.
- R5: With invert set and a nonzero threshold, the counter adds one in each cycle whose total is strictly less than the threshold. With threshold zero, invert has no effect.
- R6: In edge mode, the counter adds one on each false-to-true change of the qualified condition. With threshold zero, that condition is "total nonzero". A control write resets the edge history to false.
- R7: The kernel-level enable admits level 0 and the user-level enable admits levels 1 to 3. With neither set, all levels are counted.
- R8: With the global enable clear, the counter does not change except by software write.
- R9: A software write to the counter wins over an increment in the same cycle. That cycle raises no overflow.
- R10: A carry out of the counter wraps it modulo 2^40 and sets the status flag. Writing status with bit 0 set clears the flag; writing bit 0 as zero leaves it set. A new carry wins over a clear in the same cycle. The interrupt output is the flag ANDed with interrupt enable.
- R11: After reset, control, counter and status read zero and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_cnt | input | 96 | Per-cycle counts; sub-event s of group g occupies bits [(g*8+s)*3 +: 3] |
| priv_lvl | input | 2 | Current privilege level, 0 being most privileged |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 40 | Register write data |
| reg_rdata | output | 40 | Register read data, combinational from reg_addr |
| irq | output | 1 | Overflow interrupt |

## Verification
The hardest situation to reach is a carry out of a 40-bit counter, because counting up from zero would take far too long. The bench loads the counter through the register port a few counts below the top and applies one cycle with a large total. It first lands exactly on all-ones with no overflow, then wraps to a small known value. A second awkward case is edge history that stays high while the condition stays true. The bench rewrites the control register with the same value while the condition is held true, and expects exactly one further count.

// File: rtl/qec_pkg.sv
package qec_pkg;

    typedef struct packed {
        logic [7:0] thresh;
        logic [1:0] rsvd;
        logic       enable;
        logic       invert;
        logic       irq_en;
        logic       edge_md;
        logic       os_en;
        logic       usr_en;
        logic [7:0] umask;
        logic [7:0] code;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_CNT  = 2'd1,
        ADDR_STAT = 2'd2
    } reg_addr_t;

    typedef enum logic {
        EDG_LOW  = 1'b0,
        EDG_HIGH = 1'b1
    } edge_state_t;

    typedef enum logic {
        OVF_IDLE = 1'b0,
        OVF_PEND = 1'b1
    } ovf_state_t;

endpackage

// File: rtl/qec_select.sv
module qec_select #(
    parameter int NUM_GRP   = 4,
    parameter int NSUB      = 8,
    parameter int EVT_W     = 3,
    parameter int CODE_BASE = 32,
    parameter int SUM_W     = 6
) (
    input  logic [NUM_GRP*NSUB*EVT_W-1:0] evt_cnt,
    input  logic [7:0]                    code,
    input  logic [7:0]                    umask,
    output logic [SUM_W-1:0]              sum
);
    logic [SUM_W-1:0] grp_sum [NUM_GRP];

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        always_comb begin
            grp_sum[g] = '0;
            for (int s = 0; s < NSUB; s++) begin
                if ((umask == 8'd0) ? (s == 0) : umask[s]) begin
                    grp_sum[g] = grp_sum[g]
                        + SUM_W'(evt_cnt[(g*NSUB+s)*EVT_W +: EVT_W]);
                end
            end
        end
    end

    always_comb begin
        sum = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (code == 8'(CODE_BASE + g)) begin
                sum = grp_sum[g];
            end
        end
    end
endmodule

// File: rtl/qec_qualify.sv
module qec_qualify
    import qec_pkg::*;
#(
    parameter int SUM_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SUM_W-1:0] sum,
    input  logic [7:0]       thresh,
    input  logic             invert,
    input  logic             edge_md,
    input  logic             os_en,
    input  logic             usr_en,
    input  logic             enable,
    input  logic [1:0]       priv_lvl,
    input  logic             hist_clr,
    output logic [SUM_W-1:0] inc
);
    edge_state_t state_q, state_d;
    logic        cond;
    logic        priv_ok;
    logic        qual;

    always_comb begin
        if (thresh == 8'd0) begin
            cond = (sum != '0);
        end else if (invert) begin
            cond = 32'(sum) < 32'(thresh);
        end else begin
            cond = 32'(sum) >= 32'(thresh);
        end
        if (!os_en && !usr_en) begin
            priv_ok = 1'b1;
        end else begin
            priv_ok = (priv_lvl == 2'd0) ? os_en : usr_en;
        end
        qual = cond && priv_ok && enable;
    end

    always_comb begin
        state_d = state_q;
        if (hist_clr) begin
            state_d = EDG_LOW;
        end else begin
            unique case (state_q)
                EDG_LOW:  if (qual)  state_d = EDG_HIGH;
                EDG_HIGH: if (!qual) state_d = EDG_LOW;
                default:             state_d = EDG_LOW;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EDG_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        inc = '0;
        if (edge_md) begin
            unique case (state_q)
                EDG_LOW:  inc = qual ? SUM_W'(1) : '0;
                EDG_HIGH: inc = '0;
                default:  inc = '0;
            endcase
        end else if (qual) begin
            inc = (thresh == 8'd0) ? sum : SUM_W'(1);
        end
    end

    // R6: edge mode never adds more than one per cycle
    p_edge_unit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        edge_md |-> (inc <= SUM_W'(1)));

    // R6: without a history reset, two edge counts are never adjacent
    p_edge_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inc != '0) && $past(edge_md) && !$past(hist_clr) && edge_md)
        |-> (inc == '0));
endmodule

// File: rtl/qec_accum.sv
module qec_accum
    import qec_pkg::*;
#(
    parameter int CTR_W = 40,
    parameter int SUM_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SUM_W-1:0] inc,
    input  logic             cnt_wr,
    input  logic [CTR_W-1:0] cnt_wdata,
    input  logic             stat_clr,
    input  logic             irq_en,
    output logic [CTR_W-1:0] count,
    output logic             ovf_flag,
    output logic             irq
);
    localparam int EXT_W = CTR_W + 1;

    ovf_state_t       state_q, state_d;
    logic [EXT_W-1:0] nxt;
    logic             carry;

    assign nxt   = EXT_W'(count) + EXT_W'(inc);
    assign carry = nxt[CTR_W] && !cnt_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      count <= '0;
        else if (cnt_wr) count <= cnt_wdata;
        else             count <= nxt[CTR_W-1:0];
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OVF_IDLE: if (carry)              state_d = OVF_PEND;
            OVF_PEND: if (stat_clr && !carry) state_d = OVF_IDLE;
            default:                          state_d = OVF_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OVF_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        ovf_flag = (state_q == OVF_PEND);
        irq      = ovf_flag && irq_en;
    end

    // R9: software write wins
    p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cnt_wr) |-> (count == $past(cnt_wdata)));

    // R10: a wrap leaves the flag set
    p_wrap_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(count) > count && !$past(cnt_wr)) |-> ovf_flag);

    // R10: flag is sticky until cleared
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ovf_flag) && !$past(stat_clr)) |-> ovf_flag);
endmodule

// File: rtl/qual_event_counter.sv
module qual_event_counter
    import qec_pkg::*;
#(
    parameter int NUM_GRP   = 4,
    parameter int NSUB      = 8,
    parameter int EVT_W     = 3,
    parameter int CODE_BASE = 32,
    parameter int CTR_W     = 40
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_GRP*NSUB*EVT_W-1:0] evt_cnt,
    input  logic [1:0]                    priv_lvl,
    input  logic                          reg_wr,
    input  logic [1:0]                    reg_addr,
    input  logic [CTR_W-1:0]              reg_wdata,
    output logic [CTR_W-1:0]              reg_rdata,
    output logic                          irq
);
    localparam int MAX_SUM = NSUB * ((1 << EVT_W) - 1);
    localparam int SUM_W   = $clog2(MAX_SUM + 1);

    ctrl_t            ctrl_q;
    logic             ctrl_wr, cnt_wr, stat_clr;
    logic [SUM_W-1:0] sum, inc;
    logic [CTR_W-1:0] count;
    logic             ovf_flag;

    always_comb begin
        ctrl_wr  = reg_wr && (reg_addr == ADDR_CTRL);
        cnt_wr   = reg_wr && (reg_addr == ADDR_CNT);
        stat_clr = reg_wr && (reg_addr == ADDR_STAT) && reg_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_CTRL: reg_rdata = CTR_W'(ctrl_q);
            ADDR_CNT:  reg_rdata = count;
            ADDR_STAT: reg_rdata = CTR_W'(ovf_flag);
            default:   reg_rdata = '0;
        endcase
    end

    qec_select #(
        .NUM_GRP(NUM_GRP), .NSUB(NSUB), .EVT_W(EVT_W),
        .CODE_BASE(CODE_BASE), .SUM_W(SUM_W)
    ) u_sel (
        .evt_cnt(evt_cnt), .code(ctrl_q.code), .umask(ctrl_q.umask), .sum(sum)
    );

    qec_qualify #(.SUM_W(SUM_W)) u_qual (
        .clk(clk), .rst_n(rst_n), .sum(sum), .thresh(ctrl_q.thresh),
        .invert(ctrl_q.invert), .edge_md(ctrl_q.edge_md),
        .os_en(ctrl_q.os_en), .usr_en(ctrl_q.usr_en), .enable(ctrl_q.enable),
        .priv_lvl(priv_lvl), .hist_clr(ctrl_wr), .inc(inc)
    );

    qec_accum #(.CTR_W(CTR_W), .SUM_W(SUM_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .inc(inc), .cnt_wr(cnt_wr),
        .cnt_wdata(reg_wdata), .stat_clr(stat_clr), .irq_en(ctrl_q.irq_en),
        .count(count), .ovf_flag(ovf_flag), .irq(irq)
    );

    // R8: disabled counter holds unless written
    p_disabled_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!ctrl_q.enable) && !$past(cnt_wr)) |-> (count == $past(count)));

    // R7: kernel-only filter blocks user levels
    p_priv_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl_q.os_en && !ctrl_q.usr_en && priv_lvl != 2'd0) && !$past(cnt_wr))
        |-> (count == $past(count)));
endmodule

// File: tb/tb_qual_event_counter.sv
`timescale 1ns/1ps
module tb_qual_event_counter;
    localparam int EW = 4 * 8 * 3;
    localparam logic [39:0] TOP = 40'hFF_FFFF_FFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [EW-1:0] evt_cnt = '0;
    logic [1:0]    priv_lvl = 2'd0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [39:0]   reg_wdata = '0;
    logic [39:0]   reg_rdata;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    qual_event_counter dut (
        .clk(clk), .rst_n(rst_n), .evt_cnt(evt_cnt), .priv_lvl(priv_lvl),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [EW-1:0] ev(int g, int s, int v);
        logic [EW-1:0] r = '0;
        r[(g*8+s)*3 +: 3] = 3'(v);
        return r;
    endfunction

    // control word: code, umask, usr, os, edge, irq_en, invert, enable, thresh
    function automatic logic [39:0] cw(int code, int umask, bit usr, bit os,
                                       bit edg, bit ie, bit inv, bit en, int thr);
        return {8'd0, 8'(thr), 2'b00, en, inv, ie, edg, os, usr, 8'(umask), 8'(code)};
    endfunction

    task automatic chk(string req, logic [39:0] got, logic [39:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [39:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [39:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic step(logic [EW-1:0] v);
        evt_cnt = v;
        @(negedge clk);
    endtask

    task automatic setup(logic [39:0] c, logic [39:0] start);
        evt_cnt = '0;
        wr(2'd0, c);
        wr(2'd1, start);
    endtask

    task automatic t_reset();
        logic [39:0] v;
        rd(2'd0, v); chk("R11 ctrl", v, 40'd0);
        rd(2'd1, v); chk("R11 count", v, 40'd0);
        rd(2'd2, v); chk("R11 status", v, 40'd0);
        chk("R11 irq", 40'(irq), 40'd0);
    endtask

    task automatic t_regmap();
        logic [39:0] v;
        wr(2'd0, 40'h00_AB35_5A21);
        rd(2'd0, v); chk("R1 ctrl readback", v, 40'h00_AB35_5A21);
        wr(2'd1, 40'h12_3456_789A);
        rd(2'd1, v); chk("R1 counter readback", v, 40'h12_3456_789A);
    endtask

    task automatic t_select();
        logic [39:0] v;
        setup(cw(8'h22, 8'h05, 0, 0, 0, 0, 0, 1, 0), 40'd0);
        repeat (4) step(ev(2,0,3) | ev(2,2,4) | ev(2,1,7) | ev(1,0,7));
        rd(2'd1, v); chk("R2/R3 masked sum", v, 40'd28);
        setup(cw(8'h22, 8'h00, 0, 0, 0, 0, 0, 1, 0), 40'd0);
        repeat (2) step(ev(2,0,3) | ev(2,1,7));
        rd(2'd1, v); chk("R2 zero mask sub0", v, 40'd6);
        setup(cw(8'h30, 8'hFF, 0, 0, 0, 0, 0, 1, 0), 40'd0);
        repeat (3) step(ev(0,0,7) | ev(3,7,7));
        rd(2'd1, v); chk("R2 unmatched code", v, 40'd0);
    endtask

    task automatic t_thresh();
        logic [39:0] v;
        setup(cw(8'h21, 8'hFF, 0, 0, 0, 0, 0, 1, 3), 40'd0);
        step(ev(1,0,5)); step(ev(1,1,3)); step(ev(1,2,2)); step('0); step(ev(1,3,7));
        rd(2'd1, v); chk("R4 threshold", v, 40'd3);
        setup(cw(8'h21, 8'hFF, 0, 0, 0, 0, 1, 1, 3), 40'd0);
        step(ev(1,0,5)); step(ev(1,1,3)); step(ev(1,2,2)); step('0); step(ev(1,3,1));
        rd(2'd1, v); chk("R5 inverted", v, 40'd3);
        setup(cw(8'h21, 8'hFF, 0, 0, 0, 0, 1, 1, 0), 40'd0);
        step(ev(1,0,2)); step('0); step(ev(1,4,4));
        rd(2'd1, v); chk("R5 invert ignored at zero", v, 40'd6);
    endtask

    task automatic t_edge();
        logic [39:0] v;
        setup(cw(8'h20, 8'h01, 0, 0, 1, 0, 0, 1, 2), 40'd0);
        step(ev(0,0,3)); step(ev(0,0,3)); step(ev(0,0,3)); step('0);
        step(ev(0,0,2)); step('0); step(ev(0,0,4)); step(ev(0,0,4));
        rd(2'd1, v); chk("R6 rising edges", v, 40'd3);
        setup(cw(8'h20, 8'h01, 0, 0, 1, 0, 0, 1, 2), 40'd0);
        repeat (3) step(ev(0,0,3));
        wr(2'd0, cw(8'h20, 8'h01, 0, 0, 1, 0, 0, 1, 2));
        repeat (2) step(ev(0,0,3));
        rd(2'd1, v); chk("R6 history cleared by ctrl write", v, 40'd2);
    endtask

    task automatic t_priv();
        logic [39:0] v;
        setup(cw(8'h20, 8'h01, 0, 1, 0, 0, 0, 1, 0), 40'd0);
        priv_lvl = 2'd0; repeat (3) step(ev(0,0,1));
        priv_lvl = 2'd2; repeat (3) step(ev(0,0,1));
        rd(2'd1, v); chk("R7 kernel only", v, 40'd3);
        setup(cw(8'h20, 8'h01, 1, 0, 0, 0, 0, 1, 0), 40'd0);
        priv_lvl = 2'd0; repeat (3) step(ev(0,0,1));
        priv_lvl = 2'd3; repeat (2) step(ev(0,0,1));
        priv_lvl = 2'd1; repeat (1) step(ev(0,0,1));
        rd(2'd1, v); chk("R7 user only", v, 40'd3);
        setup(cw(8'h20, 8'h01, 0, 0, 0, 0, 0, 1, 0), 40'd0);
        priv_lvl = 2'd0; repeat (3) step(ev(0,0,1));
        priv_lvl = 2'd2; repeat (3) step(ev(0,0,1));
        rd(2'd1, v); chk("R7 neither set", v, 40'd6);
        priv_lvl = 2'd0;
    endtask

    task automatic t_enable();
        logic [39:0] v;
        setup(cw(8'h20, 8'h01, 0, 0, 0, 0, 0, 0, 0), 40'd100);
        repeat (5) step(ev(0,0,4));
        rd(2'd1, v); chk("R8 disabled", v, 40'd100);
    endtask

    task automatic t_write_prio();
        logic [39:0] v;
        setup(cw(8'h20, 8'h01, 0, 0, 0, 0, 0, 1, 0), 40'd0);
        evt_cnt = ev(0,0,2);
        wr(2'd1, 40'd50);
        rd(2'd1, v); chk("R9 write wins", v, 40'd50);
        step(ev(0,0,2));
        rd(2'd1, v); chk("R9 counting resumes", v, 40'd52);
    endtask

    task automatic t_overflow();
        logic [39:0] v;
        setup(cw(8'h20, 8'h01, 0, 0, 0, 1, 0, 1, 0), TOP - 40'd5);
        step(ev(0,0,5));
        evt_cnt = '0;
        rd(2'd1, v); chk("R10 reach all-ones", v, TOP);
        rd(2'd2, v); chk("R10 no flag without carry", v, 40'd0);
        step(ev(0,0,5));
        evt_cnt = '0;
        rd(2'd1, v); chk("R10 wrap value", v, 40'd4);
        rd(2'd2, v); chk("R10 flag set", v, 40'd1);
        chk("R10 irq high", 40'(irq), 40'd1);
        wr(2'd0, cw(8'h20, 8'h01, 0, 0, 0, 0, 0, 1, 0));
        chk("R10 irq masked", 40'(irq), 40'd0);
        wr(2'd2, 40'd0);
        rd(2'd2, v); chk("R10 zero write keeps flag", v, 40'd1);
        wr(2'd2, 40'd1);
        rd(2'd2, v); chk("R10 flag cleared", v, 40'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_select();
        t_thresh();
        t_edge();
        t_priv();
        t_enable();
        t_write_prio();
        t_overflow();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 50000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule